// File: doc/BRIEF.md
# Lane-wise parallel bit extract unit

The unit takes a data word and a mask word and splits both into equal lanes of `NB` bits. Inside every lane it collects the data bits whose mask bit is 1. It packs them against the least significant end of that lane and keeps their relative order. Every other position of the lane reads 0. Each lane is handled on its own, and no bit ever crosses from one lane into its neighbour.

The packing is done in log2(`NB`) iterations, one iteration per clock. Each iteration moves a group of bits right by a power of two (1, 2, 4, ...). A prefix-XOR of a steering word selects which bits move. That steering word starts out marking every position that has a cleared mask bit directly below it.

Operands arrive on a valid/ready input stream, and results leave on a valid/ready output stream. `in_ready` is high only while the unit is idle. An `in_valid` pulse while the unit is busy has no effect. A result waits on `out_valid` with `out_data` held steady until `out_ready` is seen. Once the result is taken, the unit goes idle again on the following cycle.

Top module: `pext_lanes`

## Requirements
- R1: In each lane, the data bits at mask-1 positions appear at result bits 0, 1, 2, ... of that lane, lowest mask position first. All higher result bits of the lane are 0.
- R2: Lanes are independent. A selected bit at the top or the bottom of a lane lands inside its own lane and never changes another lane.
- R3: `out_valid` rises on the log2(`NB`)-th rising clock edge after the edge that accepted the operands (5 edges for `NB`=32, 2 edges for `NB`=4).
- R4: `in_ready` is low from acceptance until the result is taken. An `in_valid` pulse in that window changes neither the pending result nor its timing.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change. The result is transferred on the first edge with both signals high.
- R6: After reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is 0.
- R7: An all-ones mask returns the data unchanged. An all-zero mask returns 0.
- R8: For `NB`=32, mask lane value 0x13776ECA with all-ones data gives 0x0003FFFF in that lane, because 18 selected bits are packed into bits 17..0.
- R9: The number of 1 bits in the result equals the number of 1 bits in (data AND mask).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are offered |
| in_ready | output | 1 | Unit idle and able to accept operands |
| in_data | input | W | Data word, lanes of NB bits |
| in_mask | input | W | Selection mask, same lane split |
| out_valid | output | 1 | Packed result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | W | Packed result |

## Verification
The checker takes for granted that `in_valid` and `out_ready` are never unknown after reset. It also assumes that operands matter only on the edge where `in_valid` and `in_ready` are both high. Its bit-count property relies on operands it captures at that same handshake, so an operand that changes outside the handshake must not matter.

The stimulus follows these rules. It raises `in_valid` only after it has seen `in_ready`, and it holds `in_valid` for exactly one accepting edge. On purpose, it sends one stray pulse with different operands while each operation is in flight. It also drives `out_ready` from a pseudo-random pattern, so results are held under back-pressure for varying numbers of cycles.

// File: rtl/pext_pkg.sv
package pext_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } pext_state_e;

endpackage

// File: rtl/pext_suffix.sv
// Prefix-XOR inside one lane: bit i is the XOR of bits i..0.
// Built as a log-depth doubling network.
module pext_suffix #(
  parameter int NB = 32
) (
  input  logic [NB-1:0] s_in,
  output logic [NB-1:0] p_out
);
  localparam int LVL = $clog2(NB);

  logic [NB-1:0] stage [LVL+1];

  assign stage[0] = s_in;

  for (genvar j = 0; j < LVL; j++) begin : g_lvl
    assign stage[j+1] = stage[j] ^ (stage[j] << (1 << j));
  end

  assign p_out = stage[LVL];
endmodule

// File: rtl/pext_lane_step.sv
// One packing iteration for one lane; the group size is 2**k.
module pext_lane_step #(
  parameter int NB = 32,
  parameter int KW = 3
) (
  input  logic [KW-1:0] k,
  input  logic [NB-1:0] msk_in,
  input  logic [NB-1:0] res_in,
  input  logic [NB-1:0] str_in,
  output logic [NB-1:0] msk_out,
  output logic [NB-1:0] res_out,
  output logic [NB-1:0] str_out
);
  logic [NB-1:0] odd_grp;
  logic [NB-1:0] mov_m;
  logic [NB-1:0] mov_r;
  int unsigned   gsz;

  pext_suffix #(.NB(NB)) u_sfx (
    .s_in (str_in),
    .p_out(odd_grp)
  );

  always_comb begin
    gsz     = 32'd1 << k;
    mov_m   = msk_in & odd_grp;
    mov_r   = res_in & mov_m;
    msk_out = (msk_in ^ mov_m) | (mov_m >> gsz);
    res_out = (res_in ^ mov_r) | (mov_r >> gsz);
    str_out = str_in & ~odd_grp;
  end
endmodule

// File: rtl/pext_ctrl.sv
module pext_ctrl
  import pext_pkg::*;
#(
  parameter int STEPS = 5,
  parameter int KW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic          load,
  output logic          adv,
  output logic [KW-1:0] k
);
  localparam logic [KW-1:0] K_LAST = KW'(STEPS - 1);

  pext_state_e state;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);
  assign load      = in_valid && (state == ST_IDLE);
  assign adv       = (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      k     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          state <= ST_RUN;
          k     <= '0;
        end
        ST_RUN: begin
          if (k == K_LAST) state <= ST_HOLD;
          else             k     <= k + KW'(1);
        end
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pext_lanes.sv
module pext_lanes #(
  parameter int NB = 32,
  parameter int W  = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic [W-1:0] in_mask,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int LANES = W / NB;
  localparam int STEPS = $clog2(NB);
  localparam int KW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic          load;
  logic          adv;
  logic [KW-1:0] k;

  logic [W-1:0] msk_q, res_q, str_q;
  logic [W-1:0] msk_nx, res_nx, str_nx;
  logic [W-1:0] str_init;

  pext_ctrl #(.STEPS(STEPS), .KW(KW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .load     (load),
    .adv      (adv),
    .k        (k)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // steering: inverted mask moved up one place, 0 entering at lane bit 0
    assign str_init[l*NB +: NB] = {~in_mask[l*NB +: NB-1], 1'b0};

    pext_lane_step #(.NB(NB), .KW(KW)) u_step (
      .k      (k),
      .msk_in (msk_q[l*NB +: NB]),
      .res_in (res_q[l*NB +: NB]),
      .str_in (str_q[l*NB +: NB]),
      .msk_out(msk_nx[l*NB +: NB]),
      .res_out(res_nx[l*NB +: NB]),
      .str_out(str_nx[l*NB +: NB])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_q <= '0;
      res_q <= '0;
      str_q <= '0;
    end else if (load) begin
      msk_q <= in_mask;
      res_q <= in_data & in_mask;
      str_q <= str_init;
    end else if (adv) begin
      msk_q <= msk_nx;
      res_q <= res_nx;
      str_q <= str_nx;
    end
  end

  assign out_data = res_q;
endmodule

// File: rtl/pext_lanes_chk.sv
module pext_lanes_chk #(
  parameter int NB = 32,
  parameter int W  = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic [W-1:0] in_mask,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);
  localparam int STEPS = $clog2(NB);

  logic         pend;
  logic [7:0]   cnt;
  logic [W-1:0] cap_d, cap_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      cnt   <= '0;
      cap_d <= '0;
      cap_m <= '0;
    end else if (in_valid && in_ready) begin
      pend  <= 1'b1;
      cnt   <= '0;
      cap_d <= in_data;
      cap_m <= in_mask;
    end else if (pend) begin
      if (out_valid) pend <= 1'b0;
      else           cnt  <= cnt + 8'd1;
    end
  end

  // R3
  latency_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (pend && cnt == 8'(STEPS)));

  // R4
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !out_valid) |-> !in_ready);

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($countones(out_data) == $countones(cap_d & cap_m)));

  // R6
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_ready && !out_valid && out_data == '0));
endmodule

bind pext_lanes pext_lanes_chk #(.NB(NB), .W(W)) u_chk (.*);

// File: tb/tb_pext_lanes.sv
module tb_pext_lanes;
  localparam int W = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n    = 1'b0;
  logic         sel      = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data  = '0;
  logic [W-1:0] in_mask  = '0;
  logic         ordy     = 1'b0;
  logic         ir0, ir1, ov0, ov1;
  logic [W-1:0] od0, od1;

  pext_lanes #(.NB(32), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid && !sel), .in_ready(ir0),
    .in_data(in_data), .in_mask(in_mask), .out_valid(ov0),
    .out_ready(ordy), .out_data(od0)
  );

  pext_lanes #(.NB(4), .W(W)) dut_nb4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid && sel), .in_ready(ir1),
    .in_data(in_data), .in_mask(in_mask), .out_valid(ov1),
    .out_ready(ordy), .out_data(od1)
  );

  wire         cur_ir = sel ? ir1 : ir0;
  wire         cur_ov = sel ? ov1 : ov0;
  wire [W-1:0] cur_od = sel ? od1 : od0;

  typedef struct {
    logic [W-1:0] val;
    int           acc;
    int           pc;
    string        req;
  } item_t;

  item_t        sb[$];
  int           checks = 0;
  int           fails  = 0;
  int           cyc    = 0;
  bit           run_mon = 0;
  bit           prev_ov = 0;
  bit           hold_f  = 0;
  logic [W-1:0] held;
  logic [15:0]  lfsr = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_pext(logic [W-1:0] d, logic [W-1:0] m, int nb);
    logic [W-1:0] r = '0;
    for (int l = 0; l < W / nb; l++) begin
      int pos = 0;
      for (int b = 0; b < nb; b++) begin
        if (m[l*nb + b]) begin
          r[l*nb + pos] = d[l*nb + b];
          pos++;
        end
      end
    end
    return r;
  endfunction

  // monitor: drives out_ready, checks every result leaving the unit
  always @(negedge clk) begin
    if (run_mon) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (hold_f) begin
        check("R5 held valid", {63'd0, cur_ov}, 64'd1);
        check("R5 held data", cur_od, held);
      end
      if (cur_ov && !prev_ov) begin
        if (sb.size() == 0) check("R4 unexpected result", cur_od, '0 ^ 64'd1 ^ cur_od ^ 64'd1 ^ 64'd2);
        else check("R3 latency", 64'(cyc - sb[0].acc), sel ? 64'd2 : 64'd5);
      end
      ordy = lfsr[0] | lfsr[1];
      hold_f = 0;
      if (cur_ov && sb.size() != 0) begin
        if (ordy) begin
          check(sb[0].req, cur_od, sb[0].val);
          check("R9 bit count", 64'($countones(cur_od)), 64'(sb[0].pc));
          void'(sb.pop_front());
        end else begin
          held   = cur_od;
          hold_f = 1;
        end
      end
      prev_ov = cur_ov;
    end else begin
      ordy = 1'b0;
    end
  end

  task automatic op(logic [W-1:0] d, logic [W-1:0] m, logic [W-1:0] exp, string req);
    item_t it;
    @(negedge clk);
    while (!cur_ir) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_mask  = m;
    it.val = exp;
    it.acc = cyc + 1;
    it.pc  = $countones(d & m);
    it.req = req;
    sb.push_back(it);
    @(negedge clk);
    // stray offer while busy: must be ignored
    check("R4 not ready while busy", {63'd0, cur_ir}, 64'd0);
    in_data = ~d;
    in_mask = '1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic suite(int nb);
    logic [W-1:0] d, m, e;
    op('1, {2{32'h1377_6ECA}},
       (nb == 32) ? {2{32'h0003_FFFF}} : ref_pext('1, {2{32'h1377_6ECA}}, nb),
       (nb == 32) ? "R8 packed example" : "R1 example mask");
    d = {$urandom(), $urandom()};
    op(d, '1, d, "R7 all-ones mask");
    op({$urandom(), $urandom()}, '0, '0, "R7 all-zero mask");
    d = {$urandom(), $urandom()};
    op(d, {16{4'hA}}, ref_pext(d, {16{4'hA}}, nb), "R1 alternating A");
    d = {$urandom(), $urandom()};
    op(d, {16{4'h5}}, ref_pext(d, {16{4'h5}}, nb), "R1 alternating 5");
    m = '0; e = '0;
    for (int l = 0; l < W / nb; l++) begin
      m[l*nb + nb - 1] = 1'b1;
      e[l*nb] = 1'b1;
    end
    op('1, m, e, "R2 lane top bit");
    m = '0;
    for (int l = 0; l < W / nb; l++) m[l*nb] = 1'b1;
    op(m, m, m, "R2 lane bottom bit");
    for (int i = 0; i < 30; i++) begin
      d = {$urandom(), $urandom()};
      m = {$urandom(), $urandom()};
      op(d, m, ref_pext(d, m, nb), "R1 random");
    end
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 in_ready after reset", {62'd0, ir1, ir0}, 64'd3);
    check("R6 out_valid after reset", {62'd0, ov1, ov0}, 64'd0);
    check("R6 out_data after reset", od0 | od1, '0);
    run_mon = 1;
    sel = 1'b0;
    suite(32);
    sel = 1'b1;
    suite(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule